// File: doc/BRIEF.md
# Flash Page Buffer

This block sits between a processor's instruction-fetch port and a slow, wide flash array. It keeps one or two SRAM line buffers, each one flash page wide and each with a single tag. When the processor reads a word from a page that a buffer already holds, the word is returned in the same cycle and the flash is left idle. When the read falls in any other page, a buffer is chosen and the whole page is copied from flash. The copy is a burst of 64-bit beats at ascending addresses, and the processor is stalled through a ready signal while it waits.

The flash side uses its own request/acknowledge handshake, so each beat may take any number of cycles. The processor's word is released as soon as the beat that holds it has been written, without waiting for the rest of the page. The tag is committed only once the last beat is in. With two buffers, a free buffer is used first; otherwise the buffer that was used least recently is replaced, tracked with one bit. An invalidate input drops every buffered page and cancels any burst in progress.

Top module: `flash_page_buffer`

## Requirements
- R1: While reset is held low, the flash request and processor ready outputs are low, and after reset no page counts as buffered.
- R2: A read whose page is held by a fully loaded buffer asserts ready in the same cycle as the request, with zero wait cycles and no flash beat.
- R3: A miss starts a burst whose first flash byte address is the page base (offset bits zero). Each accepted beat advances the address by 8 bytes.
- R4: On a miss, ready rises in the cycle after the beat holding the requested word is accepted, which is exactly (page offset / 8) + 1 beats into the burst.
- R5: The flash request and address hold steady until acknowledged, one beat is accepted per acknowledge, and a completed burst is exactly PAGE_BYTES/8 beats (32 by default).
- R6: A page whose burst did not finish is never reported as buffered: reading it again starts a new burst.
- R7: With two buffers, a miss fills an invalid buffer first (lowest index), otherwise the buffer least recently hit or filled.
- R8: Invalidate clears every buffer's valid state and cancels a running burst; the flash request is low in the following cycle.
- R9: When invalidate arrives in the same cycle as a burst's final acknowledge, invalidate wins and that page is not buffered afterwards.
- R10: The returned word is the 32-bit half of the 64-bit flash beat selected by address bit 2 (0 = bits 31:0, 1 = bits 63:32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_i | input | 1 | Drop all buffered pages and cancel any burst |
| cpu_req_i | input | 1 | Processor read request, held until ready |
| cpu_addr_i | input | ADDR_W | Processor byte address, word aligned |
| cpu_rdata_o | output | CPU_W | Read data, valid while ready is high |
| cpu_ready_o | output | 1 | Read completes in this cycle |
| fl_req_o | output | 1 | Flash beat request |
| fl_addr_o | output | ADDR_W | Flash byte address of the requested beat |
| fl_ack_i | input | 1 | Flash beat data valid; beat accepted this cycle |
| fl_rdata_i | input | FLASH_W | Flash beat data |

## Verification
Two events can fall in the same cycle: the acknowledge of a burst's final beat, which would commit the tag, and an invalidate. The bench watches its flash model. When 31 beats of a burst have been accepted and the final acknowledge is being presented, it raises invalidate for exactly that cycle. The outcome is judged at the ports: the flash request must drop, and a fresh read of that page must start a new burst, releasing the word after one beat instead of hitting.

// File: rtl/fpb_pkg.sv
// Shared types and helpers for the flash page buffer.
// Assumes buffer count is 1 or 2, so a buffer index fits in one bit.
package fpb_pkg;

    // Buffer index width (one or two buffers)
    localparam int BUF_W = 1;

    // Refill sequencer states
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;

    // Index width for n items, never below one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fpb_tag_unit.sv
// Tag unit: one tag and one valid bit per buffer, hit compare and victim choice.
// With two buffers a single bit remembers which buffer was used least recently.
// Assumes start and done never fall in the same cycle (start needs an idle sequencer).
module fpb_tag_unit
    import fpb_pkg::*;
#(
    parameter int NUM_BUFS = 2,
    parameter int TAG_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_i,
    input  logic [TAG_W-1:0] look_tag_i,
    input  logic             touch_i,
    input  logic             start_i,
    input  logic [BUF_W-1:0] start_buf_i,
    input  logic             done_i,
    input  logic [BUF_W-1:0] done_buf_i,
    input  logic [TAG_W-1:0] done_tag_i,
    output logic             hit_o,
    output logic [BUF_W-1:0] hit_buf_o,
    output logic [BUF_W-1:0] victim_o
);

    logic [TAG_W-1:0]    tag_q [NUM_BUFS];
    logic [NUM_BUFS-1:0] valid_q;
    logic [NUM_BUFS-1:0] match;

    // Store the tag of a buffer when its burst completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_BUFS; k++) tag_q[k] <= '0;
        end else if (done_i) begin
            for (int k = 0; k < NUM_BUFS; k++)
                if (done_buf_i == BUF_W'(k)) tag_q[k] <= done_tag_i;
        end
    end

    // Valid bits: invalidate wins, a new burst clears its buffer, completion sets it
    always_ff @(posedge clk) begin
        if (!rst_n || inv_i) begin
            valid_q <= '0;
        end else begin
            for (int k = 0; k < NUM_BUFS; k++) begin
                if (start_i && start_buf_i == BUF_W'(k)) valid_q[k] <= 1'b0;
                if (done_i && done_buf_i == BUF_W'(k))   valid_q[k] <= 1'b1;
            end
        end
    end

    // Compare the looked-up page against every valid tag
    always_comb begin
        for (int k = 0; k < NUM_BUFS; k++)
            match[k] = valid_q[k] && (tag_q[k] == look_tag_i);
    end

    assign hit_o = |match;

    generate
        if (NUM_BUFS == 2) begin : g_two
            logic lru_q;

            // Point the replacement bit away from the buffer just used
            always_ff @(posedge clk) begin
                if (!rst_n)       lru_q <= 1'b0;
                else if (done_i)  lru_q <= ~done_buf_i[0];
                else if (touch_i) lru_q <= ~match[1];
            end

            assign hit_buf_o = match[1];

            // Prefer an empty buffer, lowest index first, else the stale one
            always_comb begin
                if (!valid_q[0])      victim_o = 1'b0;
                else if (!valid_q[1]) victim_o = 1'b1;
                else                  victim_o = lru_q;
            end
        end else begin : g_one
            assign hit_buf_o = '0;
            assign victim_o  = '0;
        end
    endgenerate

endmodule

// File: rtl/fpb_refill_ctrl.sv
// Refill sequencer: walks one page from flash in ascending beats over a
// request/acknowledge handshake and reports each beat and the burst end.
// Assumes the flash holds data valid in the cycle it raises acknowledge.
module fpb_refill_ctrl
    import fpb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int TAG_W      = 8,
    parameter int BEATS      = 32,
    parameter int BEAT_W     = 5,
    parameter int PAGE_OFF_W = 8,
    parameter int BEAT_OFF_W = 3,
    localparam int CNT_W     = BEAT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_i,
    input  logic              start_i,
    input  logic [TAG_W-1:0]  start_tag_i,
    input  logic [BUF_W-1:0]  start_buf_i,
    input  logic              fl_ack_i,
    output logic              fl_req_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic              busy_o,
    output logic [TAG_W-1:0]  fill_tag_o,
    output logic [BUF_W-1:0]  fill_buf_o,
    output logic [CNT_W-1:0]  beats_done_o,
    output logic              wr_en_o,
    output logic [BEAT_W-1:0] wr_beat_o,
    output logic              done_o
);

    fill_state_e      state_q;
    logic [TAG_W-1:0] tag_q;
    logic [BUF_W-1:0] buf_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_beat;

    assign last_beat = (cnt_q == CNT_W'(BEATS - 1));

    // Sequence the burst; invalidate cancels it at once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
            cnt_q   <= '0;
            tag_q   <= '0;
            buf_q   <= '0;
        end else if (inv_i) begin
            state_q <= FILL_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                FILL_IDLE: begin
                    if (start_i) begin
                        state_q <= FILL_BUSY;
                        cnt_q   <= '0;
                        tag_q   <= start_tag_i;
                        buf_q   <= start_buf_i;
                    end
                end
                FILL_BUSY: begin
                    if (fl_ack_i) begin
                        if (last_beat) begin
                            state_q <= FILL_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: state_q <= FILL_IDLE;
            endcase
        end
    end

    assign busy_o       = (state_q == FILL_BUSY);
    assign fl_req_o     = busy_o;
    assign fl_addr_o    = (ADDR_W'(tag_q) << PAGE_OFF_W)
                        | (ADDR_W'(cnt_q[BEAT_W-1:0]) << BEAT_OFF_W);
    assign fill_tag_o   = tag_q;
    assign fill_buf_o   = buf_q;
    assign beats_done_o = cnt_q;
    assign wr_en_o      = busy_o && fl_ack_i && !inv_i;
    assign wr_beat_o    = cnt_q[BEAT_W-1:0];
    assign done_o       = wr_en_o && last_beat;

endmodule

// File: rtl/fpb_line_store.sv
// Line store: one page-wide SRAM per buffer, written one flash beat at a time,
// read one processor word at a time through a combinational mux.
// Data storage is not reset; the valid bits in the tag unit guard it.
module fpb_line_store
    import fpb_pkg::*;
#(
    parameter int NUM_BUFS = 2,
    parameter int BEATS    = 32,
    parameter int BEAT_W   = 5,
    parameter int FLASH_W  = 64,
    parameter int CPU_W    = 32,
    parameter int WSEL_W   = 1
) (
    input  logic               clk,
    input  logic               wr_en_i,
    input  logic [BUF_W-1:0]   wr_buf_i,
    input  logic [BEAT_W-1:0]  wr_beat_i,
    input  logic [FLASH_W-1:0] wr_data_i,
    input  logic [BUF_W-1:0]   rd_buf_i,
    input  logic [BEAT_W-1:0]  rd_beat_i,
    input  logic [WSEL_W-1:0]  rd_wsel_i,
    output logic [CPU_W-1:0]   rd_word_o
);

    logic [FLASH_W-1:0] beat_rd [NUM_BUFS];
    logic [FLASH_W-1:0] sel_beat;

    generate
        for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
            logic [FLASH_W-1:0] mem_q [BEATS];

            // Write an accepted flash beat into this buffer
            always_ff @(posedge clk) begin
                if (wr_en_i && wr_buf_i == BUF_W'(b))
                    mem_q[wr_beat_i] <= wr_data_i;
            end

            assign beat_rd[b] = mem_q[rd_beat_i];
        end
    endgenerate

    // Pick the buffer, then the processor word inside the beat
    always_comb begin
        sel_beat  = beat_rd[rd_buf_i];
        rd_word_o = sel_beat[CPU_W*int'(rd_wsel_i) +: CPU_W];
    end

endmodule

// File: rtl/flash_page_buffer.sv
// Flash page buffer top: serves processor reads from page-wide buffers and
// refills a buffer from flash in sequential beats on a miss, releasing the
// processor as soon as its beat is in.
// Assumes the processor holds request and address until ready, and that
// NUM_BUFS is 1 or 2 and PAGE_BYTES is a power-of-two multiple of FLASH_W/8.
module flash_page_buffer
    import fpb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 256,
    parameter int NUM_BUFS   = 2,
    parameter int FLASH_W    = 64,
    parameter int CPU_W      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inv_i,
    input  logic               cpu_req_i,
    input  logic [ADDR_W-1:0]  cpu_addr_i,
    output logic [CPU_W-1:0]   cpu_rdata_o,
    output logic               cpu_ready_o,
    output logic               fl_req_o,
    output logic [ADDR_W-1:0]  fl_addr_o,
    input  logic               fl_ack_i,
    input  logic [FLASH_W-1:0] fl_rdata_i
);

    localparam int BEAT_BYTES  = FLASH_W / 8;
    localparam int BEATS       = PAGE_BYTES / BEAT_BYTES;
    localparam int BEAT_W      = idx_width(BEATS);
    localparam int CNT_W       = BEAT_W + 1;
    localparam int PAGE_OFF_W  = $clog2(PAGE_BYTES);
    localparam int BEAT_OFF_W  = $clog2(BEAT_BYTES);
    localparam int BYTE_OFF_W  = $clog2(CPU_W / 8);
    localparam int TAG_W       = ADDR_W - PAGE_OFF_W;
    localparam int WPB         = FLASH_W / CPU_W;
    localparam int WSEL_W      = idx_width(WPB);

    logic [TAG_W-1:0]  req_tag;
    logic [BEAT_W-1:0] req_beat;
    logic [WSEL_W-1:0] req_wsel;
    logic              hit;
    logic [BUF_W-1:0]  hit_buf;
    logic [BUF_W-1:0]  victim;
    logic              busy;
    logic [TAG_W-1:0]  fill_tag;
    logic [BUF_W-1:0]  fill_buf;
    logic [CNT_W-1:0]  beats_done;
    logic              wr_en;
    logic [BEAT_W-1:0] wr_beat;
    logic              fill_done;
    logic              fill_match;
    logic              start;
    logic              touch;
    logic [BUF_W-1:0]  rd_buf;

    // Split the processor address into page, beat and word fields
    always_comb begin
        req_tag  = TAG_W'(cpu_addr_i >> PAGE_OFF_W);
        req_beat = BEAT_W'((cpu_addr_i >> BEAT_OFF_W) & ADDR_W'(BEATS - 1));
        req_wsel = WSEL_W'((cpu_addr_i >> BYTE_OFF_W) & ADDR_W'(WPB - 1));
    end

    // Early release: the requested beat of the page being filled is already written
    assign fill_match  = busy && (fill_tag == req_tag)
                       && ({1'b0, req_beat} < beats_done);
    assign cpu_ready_o = cpu_req_i && (hit || fill_match);
    assign touch       = cpu_req_i && hit;
    assign start       = cpu_req_i && !hit && !busy && !inv_i;
    assign rd_buf      = hit ? hit_buf : fill_buf;

    fpb_tag_unit #(
        .NUM_BUFS (NUM_BUFS),
        .TAG_W    (TAG_W)
    ) tag_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .inv_i       (inv_i),
        .look_tag_i  (req_tag),
        .touch_i     (touch),
        .start_i     (start),
        .start_buf_i (victim),
        .done_i      (fill_done),
        .done_buf_i  (fill_buf),
        .done_tag_i  (fill_tag),
        .hit_o       (hit),
        .hit_buf_o   (hit_buf),
        .victim_o    (victim)
    );

    fpb_refill_ctrl #(
        .ADDR_W     (ADDR_W),
        .TAG_W      (TAG_W),
        .BEATS      (BEATS),
        .BEAT_W     (BEAT_W),
        .PAGE_OFF_W (PAGE_OFF_W),
        .BEAT_OFF_W (BEAT_OFF_W)
    ) fill_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .inv_i        (inv_i),
        .start_i      (start),
        .start_tag_i  (req_tag),
        .start_buf_i  (victim),
        .fl_ack_i     (fl_ack_i),
        .fl_req_o     (fl_req_o),
        .fl_addr_o    (fl_addr_o),
        .busy_o       (busy),
        .fill_tag_o   (fill_tag),
        .fill_buf_o   (fill_buf),
        .beats_done_o (beats_done),
        .wr_en_o      (wr_en),
        .wr_beat_o    (wr_beat),
        .done_o       (fill_done)
    );

    fpb_line_store #(
        .NUM_BUFS (NUM_BUFS),
        .BEATS    (BEATS),
        .BEAT_W   (BEAT_W),
        .FLASH_W  (FLASH_W),
        .CPU_W    (CPU_W),
        .WSEL_W   (WSEL_W)
    ) store_i (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_buf_i  (fill_buf),
        .wr_beat_i (wr_beat),
        .wr_data_i (fl_rdata_i),
        .rd_buf_i  (rd_buf),
        .rd_beat_i (req_beat),
        .rd_wsel_i (req_wsel),
        .rd_word_o (cpu_rdata_o)
    );

endmodule

// File: rtl/flash_page_buffer_chk.sv
// Protocol checker for the flash page buffer, attached by bind.
// Observes the top-level ports only.
module flash_page_buffer_chk #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 256,
    parameter int FLASH_W    = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv_i,
    input logic              cpu_req_i,
    input logic              cpu_ready_o,
    input logic              fl_req_o,
    input logic [ADDR_W-1:0] fl_addr_o,
    input logic              fl_ack_i
);

    localparam int BEAT_BYTES = FLASH_W / 8;

    // R5
    flash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req_o && !fl_ack_i && !inv_i) |=> (fl_req_o && $stable(fl_addr_o)));

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req_o && fl_ack_i && !inv_i) |=>
            (!fl_req_o || fl_addr_o == $past(fl_addr_o) + ADDR_W'(BEAT_BYTES)));

    // R3
    burst_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_req_o) |-> ((fl_addr_o & ADDR_W'(PAGE_BYTES - 1)) == '0));

    // R8
    inv_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_i |=> !fl_req_o);

    // R2
    ready_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |-> cpu_req_i);

endmodule

bind flash_page_buffer flash_page_buffer_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .FLASH_W    (FLASH_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .inv_i       (inv_i),
    .cpu_req_i   (cpu_req_i),
    .cpu_ready_o (cpu_ready_o),
    .fl_req_o    (fl_req_o),
    .fl_addr_o   (fl_addr_o),
    .fl_ack_i    (fl_ack_i)
);

// File: tb/flash_page_buffer_tb_top.sv
// Bench for the flash page buffer: a flash model with fixed latency, a
// vector walk over hits, misses and replacements, then directed corner tests.
module flash_page_buffer_tb_top;

    localparam int ADDR_W = 16;
    localparam int BEATS  = 32;
    localparam int LAT    = 2;
    localparam int NVEC   = 12;

    // {expect_hit, address}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 16'h0148}, {1'b1, 16'h0104}, {1'b1, 16'h01FC}, {1'b0, 16'h023C},
        {1'b1, 16'h0108}, {1'b0, 16'h0300}, {1'b1, 16'h0110}, {1'b0, 16'h02F8},
        {1'b1, 16'h0114}, {1'b0, 16'h0304}, {1'b0, 16'h0208}, {1'b1, 16'h030C}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv = 1'b0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        fl_req;
    logic [15:0] fl_addr;
    logic        fl_ack = 1'b0;
    logic [63:0] fl_data = '0;

    int tests = 0;
    int fails = 0;
    int ack_total = 0;
    int burst_idx = 0;
    int addr_err = 0;
    int lat_cnt = 0;
    int cycles = 0;
    logic [15:0] page_base = '0;

    always #2 clk = ~clk;

    flash_page_buffer #(
        .ADDR_W(ADDR_W), .PAGE_BYTES(256), .NUM_BUFS(2), .FLASH_W(64), .CPU_W(32)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .inv_i(inv),
        .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr),
        .cpu_rdata_o(cpu_rdata), .cpu_ready_o(cpu_ready),
        .fl_req_o(fl_req), .fl_addr_o(fl_addr),
        .fl_ack_i(fl_ack), .fl_rdata_i(fl_data)
    );

    function automatic logic [63:0] fdata(input logic [15:0] a);
        return {a ^ 16'h5A5A, a, ~a, a + 16'h0101};
    endfunction

    // Flash model: fixed latency per beat, checks beat address order
    always @(posedge clk) begin
        if (fl_ack && fl_req) begin
            ack_total++;
            if (fl_addr != page_base + 16'(burst_idx * 8)) addr_err++;
            burst_idx++;
        end
        if (!fl_req || fl_ack) begin
            fl_ack  <= 1'b0;
            lat_cnt <= 0;
        end else if (lat_cnt == LAT) begin
            fl_ack  <= 1'b1;
            fl_data <= fdata(fl_addr);
        end else begin
            lat_cnt <= lat_cnt + 1;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            tests++;
            fails++;
            $display("FAIL R5 watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One processor read; waits for any burst it started to finish
    task automatic do_read(input logic [15:0] a, input bit exp_hit, input string rq);
        int base, waits, pre, beat;
        logic [31:0] got, expw;
        logic [63:0] fw;
        page_base = a & 16'hFF00;
        burst_idx = 0;
        addr_err  = 0;
        base      = ack_total;
        waits     = 0;
        cpu_addr  = a;
        cpu_req   = 1'b1;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
            waits++;
        end
        got = cpu_rdata;
        pre = ack_total - base;
        @(negedge clk);
        cpu_req = 1'b0;
        while (fl_req) @(negedge clk);
        fw   = fdata(a & 16'hFFF8);
        expw = a[2] ? fw[63:32] : fw[31:0];
        beat = int'(a & 16'h00FF) >> 3;
        check(got == expw, "R10", "read word", got, expw);
        if (exp_hit) begin
            check(pre == 0 && waits == 0, rq, "hit expected, beats before ready", pre, 0);
            check(ack_total - base == 0, "R2", "flash beats on hit", ack_total - base, 0);
        end else begin
            check(pre > 0, rq, "miss expected, beats before ready", pre, beat + 1);
            check(pre == beat + 1, "R4", "beats before ready", pre, beat + 1);
            check(ack_total - base == BEATS, "R5", "beats per burst", ack_total - base, BEATS);
            check(addr_err == 0, "R3", "beat address errors", addr_err, 0);
        end
    endtask

    // Start a miss and return once the processor word is delivered
    task automatic start_miss(input logic [15:0] a);
        page_base = a & 16'hFF00;
        burst_idx = 0;
        cpu_addr  = a;
        cpu_req   = 1'b1;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    initial begin
        // R1: reset state with a request pending
        cpu_req  = 1'b1;
        cpu_addr = 16'h0148;
        repeat (3) @(negedge clk);
        check(fl_req == 1'b0, "R1", "flash request in reset", fl_req, 0);
        check(cpu_ready == 1'b0, "R1", "ready in reset", cpu_ready, 0);
        cpu_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: first entry checks R1 (empty after reset), rest R7 replacement
        for (int i = 0; i < NVEC; i++)
            do_read(VEC[i][15:0], VEC[i][16], (i == 0) ? "R1" : "R7");

        // R8 and R6: invalidate in the middle of a burst
        start_miss(16'h0400);
        while (burst_idx < 4) @(negedge clk);
        inv = 1'b1;
        @(negedge clk);
        inv = 1'b0;
        #1;
        check(fl_req == 1'b0, "R8", "flash request after invalidate", fl_req, 0);
        @(negedge clk);
        do_read(16'h030C, 1'b0, "R8");
        do_read(16'h0400, 1'b0, "R6");

        // R9: invalidate in the cycle of the final acknowledge
        start_miss(16'h0500);
        while (!(burst_idx == BEATS - 1 && fl_ack)) @(negedge clk);
        inv = 1'b1;
        @(negedge clk);
        inv = 1'b0;
        #1;
        check(fl_req == 1'b0, "R9", "flash request after clash", fl_req, 0);
        check(burst_idx == BEATS, "R9", "beats delivered before clash", burst_idx, BEATS);
        @(negedge clk);
        do_read(16'h0500, 1'b0, "R9");
        do_read(16'h0504, 1'b1, "R2");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule